// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing of a raster display: sync pulses, a data-enable window, the pixel column and row inside the visible area, and a set of one-cycle strobes. The strobes mark the first visible pixel of each line, the first visible pixel of each frame, and the start of every frame. The start-of-frame strobe is meant for an interrupt controller. The line and frame strobes are meant for a pixel fetch engine. One pixel is produced per clock, so the clock is the pixel clock.

Each direction is built from four intervals that always run in the same sequence: sync, back porch, active, front porch. Software programs each interval, a polarity word and a run bit through a single-cycle write port. Interval and polarity writes go into holding registers. The running engine picks them up only at a frame boundary, so a frame in flight is never torn. The pixel data input is passed to the data output inside the visible area, with the programmed polarity applied.

Top module: `raster_timing_gen`

## Requirements
- R1: Each interval register holds its length minus one, in write data bits [CNT_W-1:0], so one interval can be 1 to 4096 pixels or lines long. Register addresses: 0 hsync, 1 h back porch, 2 h active, 3 h front porch, 4 vsync, 5 v back porch, 6 v active, 7 v front porch.
- R2: In each direction the intervals run in the order sync, back porch, active, front porch and then repeat. The line counter advances once, at the end of each full line.
- R3: The polarity word at address 8 works as follows. Bit 0 controls vsync, bit 1 hsync, bit 2 data enable and bit 3 pixel data; a set bit means active-high. A cleared bit 3 inverts the data output. Bit 4 is presented unchanged on `pclk_rise_o` for the clock path.
- R4: Bit 0 written to address 9 starts the engine and 0 stops it at once. While stopped, both counters sit at zero. Syncs and data enable are at their inactive levels, the visible flag and all strobes are low, and x and y are 0. The first cycle after a start is the first cycle of a frame.
- R5: Data enable and `vis_o` are asserted only when both directions are in their active intervals. There `x_o` and `y_o` give the column and row from 0; outside they read 0.
- R6: `line_start_o` pulses on the first visible pixel of every visible line. `frame_start_o` pulses only on the first visible pixel of the frame.
- R7: `vsync_evt_o` pulses for exactly one cycle per frame, on the frame's first cycle, where hsync and vsync both begin.
- R8: Interval and polarity writes made while running take effect from the first cycle of the next frame. Writes made while stopped take effect by the time of the next start.
- R9: After reset all registers are zero. The engine is stopped, hsync, vsync and data enable are high (inactive, active-low), and the data output is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | CNT_W | Register write data |
| pix_i | input | DATA_W | Pixel data from the fetch path |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable, polarity applied |
| data_o | output | DATA_W | Pixel data, blanked outside the visible area, polarity applied |
| pclk_rise_o | output | 1 | Programmed pixel clock edge select |
| vis_o | output | 1 | Visible-area flag, active-high |
| x_o | output | CNT_W | Column inside the visible area |
| y_o | output | CNT_W | Row inside the visible area |
| line_start_o | output | 1 | First visible pixel of a line |
| frame_start_o | output | 1 | First visible pixel of a frame |
| vsync_evt_o | output | 1 | Once-per-frame event for interrupt logic |

## Verification
The bound checker enforces four rules on every cycle: x and y are zero outside the visible area; x steps by one along a visible run; the frame strobe implies the line strobe at position (0,0); the frame event never lasts two cycles and follows every start. The exact interval lengths, the polarity mapping, the blanking of data and the frame-aligned take-up of new settings depend on programmed values, so only the bench's scenarios show them. The bench compares every output against a position model for several configurations, including all-minimum intervals and a 4096-pixel active line.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;

  localparam int NUM_PH   = 4;
  localparam int NUM_TREG = 2 * NUM_PH;
  localparam int POL_W    = 5;
  localparam int ADDR_W   = 4;

  localparam logic [ADDR_W-1:0] A_POL = 4'd8;
  localparam logic [ADDR_W-1:0] A_CMD = 4'd9;

  localparam int POL_V   = 0;
  localparam int POL_H   = 1;
  localparam int POL_DE  = 2;
  localparam int POL_DAT = 3;
  localparam int POL_CLK = 4;
endpackage

// File: rtl/rtg_rst_sync.sv
module rtg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/rtg_cfg_regs.sv
module rtg_cfg_regs
  import rtg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [CNT_W-1:0]              wr_data_i,
  input  logic                          frame_end_i,
  output logic [NUM_PH-1:0][CNT_W-1:0]  h_len_o,
  output logic [NUM_PH-1:0][CNT_W-1:0]  v_len_o,
  output logic [POL_W-1:0]              pol_o,
  output logic                          run_o
);
  logic [NUM_TREG-1:0][CNT_W-1:0] live_q;
  logic [NUM_TREG-1:0][CNT_W-1:0] act_q;
  logic [POL_W-1:0]               pol_live_q;
  logic [POL_W-1:0]               pol_act_q;
  logic                           run_q;
  logic                           load;

  // active copy follows the holding copy while stopped, else only at frame end
  assign load = !run_q || frame_end_i;

  for (genvar i = 0; i < NUM_TREG; i++) begin : g_treg
    logic we;
    assign we = wr_en_i && (wr_addr_i == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  live_q[i] <= '0;
      else if (we) live_q[i] <= wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    act_q[i] <= '0;
      else if (load) act_q[i] <= live_q[i];
    end

    if (i < NUM_PH) begin : g_h
      assign h_len_o[i] = act_q[i];
    end else begin : g_v
      assign v_len_o[i-NUM_PH] = act_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 pol_live_q <= '0;
    else if (wr_en_i && (wr_addr_i == A_POL))   pol_live_q <= wr_data_i[POL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pol_act_q <= '0;
    else if (load) pol_act_q <= pol_live_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 run_q <= 1'b0;
    else if (wr_en_i && (wr_addr_i == A_CMD))   run_q <= wr_data_i[0];
  end

  assign pol_o = pol_act_q;
  assign run_o = run_q;
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis
  import rtg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run_i,
  input  logic                          step_i,
  input  logic [NUM_PH-1:0][CNT_W-1:0]  len_i,
  output phase_e                        phase_o,
  output logic [CNT_W-1:0]              cnt_o,
  output logic                          last_o
);
  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd;
  logic             at_end;

  assign at_end = (cnt_q == len_i[ph_q]);
  assign upd    = !run_i || step_i;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (!run_i) begin
      ph_d  = PH_SYNC;
      cnt_d = '0;
    end else if (step_i) begin
      if (at_end) begin
        ph_d  = phase_e'(ph_q + 2'd1);
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_SYNC;
      cnt_q <= '0;
    end else if (upd) begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase_o = ph_q;
  assign cnt_o   = cnt_q;
  assign last_o  = (ph_q == PH_FRONT) && at_end;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [DATA_W-1:0] pix_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [DATA_W-1:0] data_o,
  output logic              pclk_rise_o,
  output logic              vis_o,
  output logic [CNT_W-1:0]  x_o,
  output logic [CNT_W-1:0]  y_o,
  output logic              line_start_o,
  output logic              frame_start_o,
  output logic              vsync_evt_o
);
  logic                         rst_n_s;
  logic                         run;
  logic [POL_W-1:0]             pol;
  logic [NUM_PH-1:0][CNT_W-1:0] h_len, v_len;
  phase_e                       h_ph, v_ph;
  logic [CNT_W-1:0]             h_cnt, v_cnt;
  logic                         h_last, v_last;
  logic                         frame_end;
  logic                         hs_act, vs_act, vis;
  logic [DATA_W-1:0]            pix_vis;

  rtg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  rtg_cfg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .frame_end_i (frame_end),
    .h_len_o     (h_len),
    .v_len_o     (v_len),
    .pol_o       (pol),
    .run_o       (run)
  );

  rtg_axis #(.CNT_W(CNT_W)) u_h (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .run_i   (run),
    .step_i  (1'b1),
    .len_i   (h_len),
    .phase_o (h_ph),
    .cnt_o   (h_cnt),
    .last_o  (h_last)
  );

  rtg_axis #(.CNT_W(CNT_W)) u_v (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .run_i   (run),
    .step_i  (h_last),
    .len_i   (v_len),
    .phase_o (v_ph),
    .cnt_o   (v_cnt),
    .last_o  (v_last)
  );

  assign frame_end = run && h_last && v_last;

  assign hs_act = run && (h_ph == PH_SYNC);
  assign vs_act = run && (v_ph == PH_SYNC);
  assign vis    = run && (h_ph == PH_ACT) && (v_ph == PH_ACT);

  // a set polarity bit drives the active state high
  assign hsync_o = hs_act ^ ~pol[POL_H];
  assign vsync_o = vs_act ^ ~pol[POL_V];
  assign de_o    = vis    ^ ~pol[POL_DE];

  assign pix_vis     = vis ? pix_i : '0;
  assign data_o      = pix_vis ^ {DATA_W{~pol[POL_DAT]}};
  assign pclk_rise_o = pol[POL_CLK];

  assign vis_o         = vis;
  assign x_o           = vis ? h_cnt : '0;
  assign y_o           = vis ? v_cnt : '0;
  assign line_start_o  = vis && (h_cnt == '0);
  assign frame_start_o = vis && (h_cnt == '0) && (v_cnt == '0);
  assign vsync_evt_o   = hs_act && vs_act && (h_cnt == '0) && (v_cnt == '0);
endmodule

// File: rtl/rtg_chk.sv
module rtg_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             vis_o,
  input logic [CNT_W-1:0] x_o,
  input logic [CNT_W-1:0] y_o,
  input logic             line_start_o,
  input logic             frame_start_o,
  input logic             vsync_evt_o
);
  assert_pos_zero_outside_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !vis_o |-> (x_o == '0) && (y_o == '0));

  assert_x_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vis_o && $past(vis_o) && !line_start_o) |-> (x_o == $past(x_o) + 1'b1));

  assert_frame_in_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> (line_start_o && (x_o == '0) && (y_o == '0)));

  assert_evt_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_evt_o |=> !vsync_evt_o);

  assert_start_is_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> vsync_evt_o);
endmodule

bind raster_timing_gen rtg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .run           (run),
  .vis_o         (vis_o),
  .x_o           (x_o),
  .y_o           (y_o),
  .line_start_o  (line_start_o),
  .frame_start_o (frame_start_o),
  .vsync_evt_o   (vsync_evt_o)
);

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;
  localparam int CW = 12;
  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [DW-1:0] pix = '0;
  logic          hsync, vsync, de, pclk_rise, vis, ls, fs, evt;
  logic [DW-1:0] data;
  logic [CW-1:0] x, y;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int cur [9];

  // rows: h sync, h back, h active, h front, v sync, v back, v active, v front, polarity
  localparam int NROW = 3;
  localparam int CFG [NROW][9] = '{
    '{2, 1, 4, 1, 1, 1, 3, 1, 31},
    '{1, 2, 3, 2, 2, 1, 2, 1, 0},
    '{1, 1, 1, 1, 1, 1, 1, 1, 21}
  };

  always #4 clk = ~clk;

  raster_timing_gen #(.CNT_W(CW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pix_i(pix), .hsync_o(hsync), .vsync_o(vsync),
    .de_o(de), .data_o(data), .pclk_rise_o(pclk_rise), .vis_o(vis),
    .x_o(x), .y_o(y), .line_start_o(ls), .frame_start_o(fs), .vsync_evt_o(evt)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input int v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = CW'(v);
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic program_cur();
    for (int i = 0; i < 8; i++) wr(4'(i), cur[i] - 1);   // R1: length minus one
    wr(4'd8, cur[8]);
  endtask

  // phase index and offset of position p within a sync/back/active/front sequence
  function automatic int ph_of(input int p, input int s, input int b, input int a);
    if (p < s) return 0;
    if (p < s + b) return 1;
    if (p < s + b + a) return 2;
    return 3;
  endfunction

  task automatic run_frame(input int ncyc, input int wr_t, input logic [3:0] wa, input int wv);
    int htot, vtot, ftot;
    htot = cur[0] + cur[1] + cur[2] + cur[3];
    vtot = cur[4] + cur[5] + cur[6] + cur[7];
    ftot = htot * vtot;
    for (int t = 0; t < ncyc; t++) begin
      int tf, hp, ln, hph, vph, ex, ey;
      bit evis, els, efs, eev, ehs, evs, ede;
      logic [DW-1:0] epix;
      @(negedge clk);
      pix = DW'(t * 37 + 5);
      if (t == wr_t) begin wr_en = 1'b1; wr_addr = wa; wr_data = CW'(wv); end
      else wr_en = 1'b0;
      #1;
      tf  = t % ftot;
      hp  = tf % htot;
      ln  = tf / htot;
      hph = ph_of(hp, cur[0], cur[1], cur[2]);
      vph = ph_of(ln, cur[4], cur[5], cur[6]);
      evis = (hph == 2) && (vph == 2);
      ex   = evis ? hp - cur[0] - cur[1] : 0;
      ey   = evis ? ln - cur[4] - cur[5] : 0;
      els  = evis && (ex == 0);
      efs  = els && (ey == 0);
      eev  = (hp == 0) && (ln == 0);
      ehs  = (hph == 0) ^ !cur[8][1];
      evs  = (vph == 0) ^ !cur[8][0];
      ede  = evis ^ !cur[8][2];
      epix = (evis ? pix : '0) ^ {DW{!cur[8][3]}};
      chk({hsync, vsync, pclk_rise} == {ehs, evs, cur[8][4]}, "R2/R3 sync order and polarity",
          64'({hsync, vsync, pclk_rise}), 64'({ehs, evs, cur[8][4]}));
      chk({vis, de, x, y} == {evis, ede, CW'(ex), CW'(ey)}, "R5 visible window and position",
          64'({vis, de, x, y}), 64'({evis, ede, CW'(ex), CW'(ey)}));
      chk({ls, fs, evt} == {els, efs, eev}, "R6/R7 strobes and frame event",
          64'({ls, fs, evt}), 64'({els, efs, eev}));
      chk(data == epix, "R3 data blanking and polarity", 64'(data), 64'(epix));
    end
    wr_en = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    pix = 24'h123456;
    #1;
    // R9: stopped, active-low inactive levels, data all ones
    chk({hsync, vsync, de, vis, ls, fs, evt, pclk_rise} == 8'b1110_0000, "R9 reset levels",
        64'({hsync, vsync, de, vis, ls, fs, evt, pclk_rise}), 64'h0e0);
    chk(data == {DW{1'b1}}, "R9 reset data", 64'(data), 64'({DW{1'b1}}));

    // table walk: program with engine stopped, start, check a full frame (R1, R2, R3, R8)
    for (int r = 0; r < NROW; r++) begin
      wr(4'd9, 0);
      for (int i = 0; i < 9; i++) cur[i] = CFG[r][i];
      program_cur();
      wr(4'd9, 1);
      run_frame((cur[0]+cur[1]+cur[2]+cur[3]) * (cur[4]+cur[5]+cur[6]+cur[7]) * 2, -1, 4'd0, 0);
    end

    // R8: change h active mid-frame; current frame unchanged, next frame uses 5 pixels
    wr(4'd9, 0);
    for (int i = 0; i < 9; i++) cur[i] = CFG[0][i];
    program_cur();
    wr(4'd9, 1);
    run_frame(48, 10, 4'd2, 4);
    cur[2] = 5;
    run_frame(54, 20, 4'd8, 0);   // polarity write mid-frame
    cur[8] = 0;
    run_frame(54, -1, 4'd0, 0);

    // R4: stop mid-frame, everything idle and inactive, then restart at frame start
    run_frame(20, -1, 4'd0, 0);
    wr(4'd9, 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #1;
      chk({hsync, vsync, de, vis, ls, fs, evt} == 7'b1110000, "R4 idle levels",
          64'({hsync, vsync, de, vis, ls, fs, evt}), 64'h70);
      chk({x, y} == '0, "R4 idle position", 64'({x, y}), 64'h0);
    end
    wr(4'd9, 1);
    run_frame(54, -1, 4'd0, 0);

    // R1 boundary: 4096-pixel active line (field value 4095), three lines
    wr(4'd9, 0);
    cur = '{1, 1, 4096, 1, 1, 1, 1, 1, 31};
    program_cur();
    wr(4'd9, 1);
    run_frame(3 * 4099, -1, 4'd0, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule